// File: doc/BRIEF.md
# Vector Gather Line Coalescer

This unit serves one vector gather per request: a base word address together with eight 32-bit word offsets, all handed over in a single transfer. The unit returns a 256-bit vector made of the eight addressed words. Lanes are not handled one at a time. The unit sorts the lanes by the cache line they fall in. In each cycle it reads up to two different lines through two line-wide read ports and fills every outstanding lane that hits either of them.

Addresses that share lines therefore cost little. When all enabled lanes fall within one or two lines, a gather spends one cycle in the unit, and with the consumer ready a new request is taken every cycle. Scattered addresses cost one cycle for each pair of distinct lines, so the worst case is four cycles. A per-lane enable mask drops lanes from the gather, and each dropped lane returns zero. The line store sits outside the unit: each read port is answered in the same cycle by whoever owns the lines.

Back-pressure: a request transfers on a clock edge where `req_valid` and `req_ready` are both high. A response transfers on an edge where `rsp_valid` and `rsp_ready` are both high. A finished gather whose result cannot enter the output register waits inside the unit, and the unit takes no new request until that result moves out.

Top module: `vgather_coalesce`

## Requirements
- R1: A request carries the base word address, all eight offsets and the enable mask in one handshake. Lane l uses offset bits [32l+31:32l], and its word address is base plus offset modulo 2^32. The line index is word address bits [31:4] and the word within the line is bits [3:0].
- R2: For an enabled lane l, rsp_data bits [32l+31:32l] equal the 32-bit word stored at that lane's word address. A line image on a read port holds word w of the line at bits [32w+31:32w].
- R3: A lane whose enable bit is 0 returns zero in its result slot, and its line is never read on its behalf.
- R4: No more than two lines are read in one cycle. rd1_en is high only together with rd0_en, and only for a line index different from rd0_line.
- R5: Line choice in each cycle: port 0 reads the line of the lowest-numbered enabled lane that is still unfilled. Port 1 reads the line of the lowest-numbered unfilled enabled lane whose line differs from port 0's line. When no such lane exists, port 1 stays idle.
- R6: With n distinct lines among the enabled lanes, a gather spends max(1, ceil(n/2)) cycles in the unit. rsp_valid rises at the clock edge that ends the last of those cycles, provided the output register is free.
- R7: When every request touches at most two lines and rsp_ready stays high, req_ready stays high. One request is accepted per cycle and the responses follow in order on consecutive cycles.
- R8: A gather whose eight lanes hit eight distinct lines reads for exactly four cycles.
- R9: While rsp_valid is high and rsp_ready is low, rsp_valid and rsp_data hold steady. After the response transfers, rsp_valid falls unless another gather completes on the same edge.
- R10: req_ready is high whenever no gather is in progress. While a gather is in progress, req_ready is high only in the cycle where that gather completes and the output register is free (rsp_valid low or rsp_ready high).
- R11: During reset and at its release, rsp_valid, rd0_en and rd1_en are low and req_ready is high.
- R12: A request with every lane disabled issues no read. It completes after one cycle with an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_base_word | input | WADDR_W (32) | Base word address |
| req_offsets | input | LANES*WADDR_W (256) | Per-lane word offsets, lane l at [32l+31:32l] |
| req_lane_en | input | LANES (8) | Per-lane enable; 0 drops the lane |
| rd0_en | output | 1 | Read port 0 active |
| rd0_line | output | LIDX_W (28) | Line index read on port 0 |
| rd0_data | input | LINE_BITS (512) | Line image for port 0, same cycle |
| rd1_en | output | 1 | Read port 1 active |
| rd1_line | output | LIDX_W (28) | Line index read on port 1 |
| rd1_data | input | LINE_BITS (512) | Line image for port 1, same cycle |
| rsp_valid | output | 1 | Gathered vector valid |
| rsp_ready | input | 1 | Consumer ready |
| rsp_data | output | LANES*WORD_W (256) | Gathered vector, lane l at [32l+31:32l] |

## Verification
The bench builds the unit with its defaults: eight lanes, 32-bit words and sixteen-word lines. At this size every pattern of the enable mask can be swept, and line counts from one to eight can be produced through the offsets. The sweep includes offsets that wrap the 32-bit word address and bases that push lanes across line boundaries. At each of these points the bench checks the per-cycle line choice, the latency and the data against its own arithmetic schedule. Separate sequences stream one-line and two-line requests back to back, and they stall the consumer while a second gather waits behind the output.

// File: rtl/vgc_pkg.sv
package vgc_pkg;

  // Control state of the gather engine.
  typedef enum logic [1:0] {
    GS_IDLE  = 2'd0,  // no gather held
    GS_RUN   = 2'd1,  // lanes still waiting for their lines
    GS_DRAIN = 2'd2   // all lanes filled, output register busy
  } gstate_e;

endpackage

// File: rtl/vgc_lane_addr.sv
// Word address of one lane, split into line index and word select.
module vgc_lane_addr #(
  parameter int WADDR_W    = 32,
  parameter int LINE_WORDS = 16,
  localparam int WSEL_W = $clog2(LINE_WORDS),
  localparam int LIDX_W = WADDR_W - WSEL_W
) (
  input  logic [WADDR_W-1:0] base_word,
  input  logic [WADDR_W-1:0] offset,
  output logic [LIDX_W-1:0]  line_idx,
  output logic [WSEL_W-1:0]  word_sel
);

  logic [WADDR_W-1:0] word_addr;

  // Wraps modulo 2^WADDR_W.
  assign word_addr = base_word + offset;
  assign line_idx  = word_addr[WADDR_W-1:WSEL_W];
  assign word_sel  = word_addr[WSEL_W-1:0];

endmodule

// File: rtl/vgc_line_pick.sv
// Chooses up to two distinct lines among pending lanes and flags the hits.
module vgc_line_pick #(
  parameter int LANES  = 8,
  parameter int LIDX_W = 28
) (
  input  logic [LANES-1:0]        pending,
  input  logic [LANES*LIDX_W-1:0] lines_flat,
  output logic                    sel0_v,
  output logic [LIDX_W-1:0]       sel0_line,
  output logic                    sel1_v,
  output logic [LIDX_W-1:0]       sel1_line,
  output logic [LANES-1:0]        hit0,
  output logic [LANES-1:0]        hit1
);

  logic [LIDX_W-1:0] lane_line [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_unpack
    assign lane_line[l] = lines_flat[l*LIDX_W +: LIDX_W];
  end

  // First choice: lowest pending lane.
  always_comb begin
    sel0_v    = 1'b0;
    sel0_line = '0;
    for (int l = 0; l < LANES; l++) begin
      if (pending[l] && !sel0_v) begin
        sel0_v    = 1'b1;
        sel0_line = lane_line[l];
      end
    end
  end

  // Second choice: lowest pending lane on another line.
  always_comb begin
    sel1_v    = 1'b0;
    sel1_line = '0;
    for (int l = 0; l < LANES; l++) begin
      if (pending[l] && (lane_line[l] != sel0_line) && !sel1_v) begin
        sel1_v    = 1'b1;
        sel1_line = lane_line[l];
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_hit
    assign hit0[l] = pending[l] && sel0_v && (lane_line[l] == sel0_line);
    assign hit1[l] = pending[l] && sel1_v && (lane_line[l] == sel1_line);
  end

endmodule

// File: rtl/vgc_lane_fill.sv
// Extracts one lane's word from whichever read port serves it.
module vgc_lane_fill #(
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 16,
  localparam int WSEL_W    = $clog2(LINE_WORDS),
  localparam int LINE_BITS = LINE_WORDS * WORD_W
) (
  input  logic                 hit0,
  input  logic                 hit1,
  input  logic [WSEL_W-1:0]    word_sel,
  input  logic [LINE_BITS-1:0] line0,
  input  logic [LINE_BITS-1:0] line1,
  output logic                 fill,
  output logic [WORD_W-1:0]    word
);

  int unsigned idx;

  assign fill = hit0 || hit1;

  always_comb begin
    idx = int'(word_sel) * WORD_W;
    if (hit0) begin
      word = line0[idx +: WORD_W];
    end else if (hit1) begin
      word = line1[idx +: WORD_W];
    end else begin
      word = '0;
    end
  end

endmodule

// File: rtl/vgather_coalesce.sv
module vgather_coalesce
  import vgc_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int WORD_W     = 32,
  parameter int WADDR_W    = 32,
  parameter int LINE_WORDS = 16,
  localparam int WSEL_W    = $clog2(LINE_WORDS),
  localparam int LIDX_W    = WADDR_W - WSEL_W,
  localparam int LINE_BITS = LINE_WORDS * WORD_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [WADDR_W-1:0]        req_base_word,
  input  logic [LANES*WADDR_W-1:0]  req_offsets,
  input  logic [LANES-1:0]          req_lane_en,
  output logic                      rd0_en,
  output logic [LIDX_W-1:0]         rd0_line,
  input  logic [LINE_BITS-1:0]      rd0_data,
  output logic                      rd1_en,
  output logic [LIDX_W-1:0]         rd1_line,
  input  logic [LINE_BITS-1:0]      rd1_data,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [LANES*WORD_W-1:0]   rsp_data
);

  gstate_e state_q, state_d;

  logic [LIDX_W-1:0] req_line    [LANES];
  logic [WSEL_W-1:0] req_wsel    [LANES];
  logic [LIDX_W-1:0] lane_line_q [LANES];
  logic [WSEL_W-1:0] lane_wsel_q [LANES];
  logic [WORD_W-1:0] work_q      [LANES];
  logic [WORD_W-1:0] fetched     [LANES];
  logic [WORD_W-1:0] merged      [LANES];

  logic [LANES-1:0]        filled_q, filled_nx, pending, fill_now, hit0, hit1;
  logic [LANES*LIDX_W-1:0] lines_flat;
  logic [LANES*WORD_W-1:0] merged_flat, rsp_data_q;
  logic                    sel0_v, sel1_v;
  logic [LIDX_W-1:0]       sel0_line, sel1_line;
  logic                    all_nx, out_free, finish, accept, running, rsp_valid_q;

  // Per-lane address split, word extraction and result merge.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vgc_lane_addr #(
      .WADDR_W   (WADDR_W),
      .LINE_WORDS(LINE_WORDS)
    ) u_addr (
      .base_word(req_base_word),
      .offset   (req_offsets[l*WADDR_W +: WADDR_W]),
      .line_idx (req_line[l]),
      .word_sel (req_wsel[l])
    );

    vgc_lane_fill #(
      .WORD_W    (WORD_W),
      .LINE_WORDS(LINE_WORDS)
    ) u_fill (
      .hit0    (hit0[l]),
      .hit1    (hit1[l]),
      .word_sel(lane_wsel_q[l]),
      .line0   (rd0_data),
      .line1   (rd1_data),
      .fill    (fill_now[l]),
      .word    (fetched[l])
    );

    assign lines_flat[l*LIDX_W +: LIDX_W]   = lane_line_q[l];
    assign merged[l]                        = fill_now[l] ? fetched[l] : work_q[l];
    assign merged_flat[l*WORD_W +: WORD_W]  = merged[l];

    always_ff @(posedge clk) begin
      if (accept) begin
        lane_line_q[l] <= req_line[l];
        lane_wsel_q[l] <= req_wsel[l];
        work_q[l]      <= '0;
      end else if (running) begin
        work_q[l]      <= merged[l];
      end
    end
  end

  assign running = (state_q == GS_RUN);
  assign pending = running ? ~filled_q : '0;

  vgc_line_pick #(
    .LANES (LANES),
    .LIDX_W(LIDX_W)
  ) u_pick (
    .pending   (pending),
    .lines_flat(lines_flat),
    .sel0_v    (sel0_v),
    .sel0_line (sel0_line),
    .sel1_v    (sel1_v),
    .sel1_line (sel1_line),
    .hit0      (hit0),
    .hit1      (hit1)
  );

  assign rd0_en   = sel0_v;
  assign rd0_line = sel0_line;
  assign rd1_en   = sel1_v;
  assign rd1_line = sel1_line;

  // Completion and handshakes.
  assign filled_nx = filled_q | fill_now;
  assign all_nx    = &filled_nx;
  assign out_free  = !rsp_valid_q || rsp_ready;
  assign finish    = (state_q != GS_IDLE) && all_nx && out_free;
  assign req_ready = (state_q == GS_IDLE) || finish;
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d = state_q;
    if ((state_q == GS_IDLE) || finish) begin
      state_d = accept ? GS_RUN : GS_IDLE;
    end else if (running && all_nx) begin
      state_d = GS_DRAIN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= GS_IDLE;
      rsp_valid_q <= 1'b0;
      filled_q    <= '1;
    end else begin
      state_q <= state_d;
      if (finish) begin
        rsp_valid_q <= 1'b1;
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
      if (accept) begin
        filled_q <= ~req_lane_en;
      end else if (running) begin
        filled_q <= filled_nx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (finish) begin
      rsp_data_q <= merged_flat;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/vgc_checker.sv
module vgc_checker #(
  parameter int LANES  = 8,
  parameter int LIDX_W = 28,
  parameter int RSP_W  = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd0_en,
  input logic [LIDX_W-1:0] rd0_line,
  input logic              rd1_en,
  input logic [LIDX_W-1:0] rd1_line,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [RSP_W-1:0]  rsp_data
);

  localparam int CNT_W = $clog2(LANES) + 2;

  // Read cycles since the most recent accepted request.
  logic [CNT_W-1:0] rd_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cycles <= '0;
    end else if (req_valid && req_ready) begin
      rd_cycles <= '0;
    end else if (rd0_en) begin
      rd_cycles <= rd_cycles + 1'b1;
    end
  end

  p_two_lines_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd1_en |-> (rd0_en && (rd1_line != rd0_line)));

  p_hold_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_busy_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_en && rsp_valid && !rsp_ready) |-> !req_ready);

  p_max_reads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_en |-> (rd_cycles < CNT_W'(LANES / 2)));

  p_reset_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rsp_valid && req_ready && !rd0_en && !rd1_en));

endmodule

bind vgather_coalesce vgc_checker #(
  .LANES (LANES),
  .LIDX_W(LIDX_W),
  .RSP_W (LANES * WORD_W)
) u_vgc_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rd0_en   (rd0_en),
  .rd0_line (rd0_line),
  .rd1_en   (rd1_en),
  .rd1_line (rd1_line),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data)
);

// File: tb/vgather_coalesce_bench.sv
module vgather_coalesce_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic         req_ready;
  logic [31:0]  req_base_word;
  logic [255:0] req_offsets;
  logic [7:0]   req_lane_en;
  logic         rd0_en, rd1_en;
  logic [27:0]  rd0_line, rd1_line;
  logic [511:0] rd0_data, rd1_data;
  logic         rsp_valid;
  logic         rsp_ready;
  logic [255:0] rsp_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vgather_coalesce u_vgather_coalesce (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_base_word(req_base_word),
    .req_offsets  (req_offsets),
    .req_lane_en  (req_lane_en),
    .rd0_en       (rd0_en),
    .rd0_line     (rd0_line),
    .rd0_data     (rd0_data),
    .rd1_en       (rd1_en),
    .rd1_line     (rd1_line),
    .rd1_data     (rd1_data),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_data     (rsp_data)
  );

  // Memory contents: a fixed arithmetic function of the word address.
  function automatic logic [31:0] mem_word(input logic [31:0] wa);
    return (wa * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
  endfunction

  function automatic logic [511:0] line_image(input logic [27:0] line);
    logic [511:0] img;
    for (int w = 0; w < 16; w++) img[w*32 +: 32] = mem_word({line, 4'(w)});
    return img;
  endfunction

  always_comb begin
    rd0_data = line_image(rd0_line);
    rd1_data = line_image(rd1_line);
  end

  function automatic logic [255:0] expect_vec(input logic [31:0] base,
                                              input logic [255:0] offs,
                                              input logic [7:0] en);
    logic [255:0] v;
    for (int l = 0; l < 8; l++)
      v[l*32 +: 32] = en[l] ? mem_word(base + offs[l*32 +: 32]) : 32'h0;
    return v;
  endfunction

  // Offsets for k line groups; variant v reshuffles lanes, v==3 wraps below zero.
  function automatic logic [255:0] pat_offs(input int k, input int v);
    logic [255:0] r;
    for (int l = 0; l < 8; l++) begin
      int grp = (l * (2 * v + 1) + v) % k;
      int w   = (l * 5 + v) % 16;
      logic [31:0] o = 32'(grp * 32 + w);
      if (v == 3) o = o - 32'd64;
      r[l*32 +: 32] = o;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_gather(input logic [31:0] base, input logic [255:0] offs,
                            input logic [7:0] en, input bit stall);
    logic [27:0]  lines [8];
    logic [27:0]  l0 [8];
    logic [27:0]  l1 [8];
    bit           h1 [8];
    logic [7:0]   filled;
    logic [255:0] exp;
    logic [255:0] held;
    int steps = 0;
    int n = 0;
    int cyc = 0;
    int exp_cyc;
    for (int l = 0; l < 8; l++) begin
      logic [31:0] wa = base + offs[l*32 +: 32];
      lines[l] = wa[31:4];
    end
    // Schedule model: R5 selection rule.
    filled = ~en;
    while (filled != 8'hFF) begin
      int f0 = -1;
      int f1 = -1;
      for (int l = 0; l < 8; l++) if (!filled[l] && f0 < 0) f0 = l;
      for (int l = 0; l < 8; l++)
        if (!filled[l] && f1 < 0 && lines[l] != lines[f0]) f1 = l;
      l0[steps] = lines[f0];
      h1[steps] = (f1 >= 0);
      l1[steps] = (f1 >= 0) ? lines[f1] : 28'h0;
      for (int l = 0; l < 8; l++)
        if (!filled[l] && (lines[l] == l0[steps] || (h1[steps] && lines[l] == l1[steps])))
          filled[l] = 1'b1;
      steps++;
    end
    for (int l = 0; l < 8; l++) begin
      bit seen = 0;
      for (int j = 0; j < l; j++) if (en[j] && en[l] && lines[j] == lines[l]) seen = 1;
      if (en[l] && !seen) n++;
    end
    exp = expect_vec(base, offs, en);

    @(negedge clk);
    req_valid     = 1'b1;
    req_base_word = base;
    req_offsets   = offs;
    req_lane_en   = en;
    chk(req_ready == 1'b1, "R10", "idle req_ready", 256'(req_ready), 256'(1));
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && cyc < 12) begin
      if (cyc < steps) begin
        chk(rd0_en && rd0_line == l0[cyc] && rd1_en == h1[cyc] &&
            (!h1[cyc] || rd1_line == l1[cyc]), "R5", "line choice",
            {rd1_en, rd1_line, rd0_en, rd0_line},
            {h1[cyc], l1[cyc], 1'b1, l0[cyc]});
      end else begin
        chk(!rd0_en && !rd1_en, (en == 8'h00) ? "R12" : "R3", "no read expected",
            256'({rd1_en, rd0_en}), 256'(0));
      end
      cyc++;
      @(negedge clk);
    end
    exp_cyc = (steps == 0) ? 1 : steps;
    chk(cyc == exp_cyc, (en == 8'h00) ? "R12" : "R6", "latency",
        256'(cyc), 256'(exp_cyc));
    chk(steps == (n + 1) / 2 || (n == 0 && steps == 0), "R6", "model line pairs",
        256'(steps), 256'((n + 1) / 2));
    if (n == 8) chk(cyc == 4, "R8", "eight lines", 256'(cyc), 256'(4));
    for (int l = 0; l < 8; l++) begin
      chk(rsp_data[l*32 +: 32] == exp[l*32 +: 32], en[l] ? "R2" : "R3",
          en[l] ? "R1 lane word" : "disabled lane",
          256'(rsp_data[l*32 +: 32]), 256'(exp[l*32 +: 32]));
    end
    if (stall) begin
      rsp_ready = 1'b0;
      held = rsp_data;
      repeat (3) begin
        @(negedge clk);
        chk(rsp_valid && rsp_data == held, "R9", "held response", rsp_data, held);
      end
      rsp_ready = 1'b1;
    end
    @(negedge clk);
    chk(!rsp_valid, "R9", "valid drops after transfer", 256'(rsp_valid), 256'(0));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL R6 watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
    end
  end

  initial begin
    logic [255:0] bo [6];
    logic [31:0]  bb [6];
    logic [255:0] ea, eb;
    rst_n         = 1'b0;
    req_valid     = 1'b0;
    req_base_word = '0;
    req_offsets   = '0;
    req_lane_en   = '0;
    rsp_ready     = 1'b1;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !rd0_en && !rd1_en && req_ready, "R11", "in reset",
        256'({rsp_valid, rd0_en, rd1_en, req_ready}), 256'(1));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rsp_valid && !rd0_en && !rd1_en && req_ready, "R11", "after release",
        256'({rsp_valid, rd0_en, rd1_en, req_ready}), 256'(1));

    // Line-count sweep across shuffles, line offsets and address wrap.
    for (int k = 1; k <= 8; k++)
      for (int v = 0; v < 4; v++)
        for (int bi = 0; bi < 3; bi++) begin
          int b = (bi == 0) ? 0 : ((bi == 1) ? 5 : 13);
          logic [31:0] base = (v == 3) ? 32'(b) : 32'h100 + 32'(b);
          run_gather(base, pat_offs(k, v), 8'hFF, ((k + v + b) % 5) == 0);
        end

    // Every enable mask over an eight-line pattern (R3, R12).
    for (int m = 0; m < 256; m++) run_gather(32'h203, pat_offs(8, 1), 8'(m), 1'b0);

    // R7: back-to-back one- and two-line requests.
    for (int i = 0; i < 6; i++) begin
      bb[i] = 32'h2000 + 32'(i * 64);
      for (int l = 0; l < 8; l++)
        bo[i][l*32 +: 32] = 32'(l + (((i % 2) == 1 && l >= 4) ? 16 : 0));
    end
    @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      if (k < 6) begin
        req_valid     = 1'b1;
        req_base_word = bb[k];
        req_offsets   = bo[k];
        req_lane_en   = 8'hFF;
        chk(req_ready == 1'b1, "R7", "ready every cycle", 256'(req_ready), 256'(1));
      end else begin
        req_valid = 1'b0;
      end
      if (k >= 2) begin
        ea = expect_vec(bb[k-2], bo[k-2], 8'hFF);
        chk(rsp_valid && rsp_data == ea, "R7", "streamed result", rsp_data, ea);
      end
      @(negedge clk);
    end
    chk(!rsp_valid, "R7", "stream drained", 256'(rsp_valid), 256'(0));

    // R10: second gather waits behind a stalled output.
    rsp_ready = 1'b0;
    req_valid     = 1'b1;
    req_base_word = 32'h3000;
    req_offsets   = bo[1];
    req_lane_en   = 8'hFF;
    ea = expect_vec(32'h3000, bo[1], 8'hFF);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid && rsp_data == ea, "R9", "first result stalled", rsp_data, ea);
    req_valid     = 1'b1;
    req_base_word = 32'h4000;
    req_offsets   = bo[0];
    req_lane_en   = 8'h5A;
    eb = expect_vec(32'h4000, bo[0], 8'h5A);
    chk(req_ready == 1'b1, "R10", "idle while output full", 256'(req_ready), 256'(1));
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) begin
      chk(!req_ready, "R10", "busy behind stalled output", 256'(req_ready), 256'(0));
      chk(rsp_valid && rsp_data == ea, "R9", "output unchanged", rsp_data, ea);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid && rsp_data == eb, "R9", "next result on same edge", rsp_data, eb);
    @(negedge clk);
    chk(!rsp_valid, "R9", "output empty", 256'(rsp_valid), 256'(0));

    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

endmodule